// File: doc/BRIEF.md
# I2C Random-Read Sequencer

This block runs a complete random-address read from an I2C memory device. It does this by issuing register accesses to a byte-wide I2C master controller that reports its progress as a status code. A one-cycle `start` pulse captures four things: the device address byte, a 16-bit offset, a flag that selects a one- or two-byte offset, and a byte count. The sequencer then runs a fixed script of register accesses. Each step writes the controller's control register and polls the status register until the code expected for that step appears. Data bytes come out on a valid/data stream as they are fetched. The run ends with a one-cycle `done` pulse carrying the byte count, or a one-cycle `err` pulse carrying the last status code observed.

The states are IDLE, INIT, ISSUE, WAIT, POLL_RD, POLL_CHK, DATA_RD, DATA_CAP, NEXT, DONE and ERR. The transitions are as follows:

- IDLE goes to INIT on an accepted start, or to ERR when the count is zero.
- INIT issues four set-up writes and then goes to ISSUE.
- ISSUE writes the data register when the step carries a byte, then writes the control register, then goes to WAIT.
- WAIT holds for the poll delay and then goes to POLL_RD.
- POLL_RD goes to POLL_CHK.
- POLL_CHK goes to DATA_RD on a match in a read step, to NEXT on a match in any other step, back to WAIT on a mismatch with polls left, and to ERR when the poll budget is spent.
- DATA_RD goes to DATA_CAP, and DATA_CAP goes to NEXT.
- NEXT picks the following step and goes to ISSUE, or goes to DONE after the STOP step.
- DONE and ERR return to IDLE.

The script steps are ENABLE, START, ADDR_W, OFS_HI, OFS_LO, RSTART, ADDR_R, READ (repeated) and STOP.

Top module: `i2c_rdseq`

## Requirements
- R1: After an accepted start, the first four accesses are writes: 0x00 to register 0x1C, 0x00 to register 0x00, 0x00 to register 0x10, and 0x24 to register 0x0C. These are followed by a control write (register 0x08) of 0x40 (enable), which must return status 0xF8.
- R2: The control bits are ACK=0x04, STOP=0x10, START=0x20 and enable=0x40. START is written as 0x60 and must return 0x08. The device address with bit 0 cleared is then sent with control 0x40 and must return 0x18. A repeated START (0x60) must return 0x10. The address with bit 0 set (control 0x40) must return 0x40.
- R3: The offset high byte is sent only when the two-byte flag is 1. The offset low byte is always sent. Each offset byte is written with control 0x40 and must return 0x28.
- R4: Every byte except the last is requested with control 0x44 and must return 0x50. The last byte is requested with control 0x40 and must return 0x58. Each byte read from the data register (0x04) appears once on `rx_data` with `rx_valid`, in address order.
- R5: After the last byte, control 0x50 (STOP with enable) is written and must return 0xF8. Then `done` pulses for one cycle with `done_count` equal to the requested count. `done` and `err` are never high together.
- R6: In every step that sends a byte, the data register (0x04) is written in the cycle just before the control register. The data register is read only after the status poll has matched. The block never reads and writes in the same cycle.
- R7: Status polls within one step are POLL_DELAY+2 cycles apart, and the first poll falls POLL_DELAY+1 cycles after the control write. When MAX_POLLS polls have all missed, `err` pulses with `err_status` equal to the last status read.
- R8: A start with count 0 raises `err` in the following cycle with `err_status` 0x00. No register access is made.
- R9: A start pulse that arrives while `busy` is high is ignored, and the running transaction completes unchanged.
- R10: After reset, `busy`, `done`, `err`, `rx_valid`, `reg_wr_en` and `reg_rd_en` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a read |
| dev_addr | input | 8 | Device address byte; bit 0 is replaced by the sequencer |
| offset | input | 16 | Memory offset to read from |
| offset_two | input | 1 | 1: two-byte offset, 0: one-byte offset |
| count | input | CNT_W | Number of bytes to read |
| busy | output | 1 | High from an accepted start until the cycle after done or err |
| rx_valid | output | 1 | A read byte is present on rx_data |
| rx_data | output | 8 | Read byte |
| done | output | 1 | One-cycle pulse on successful completion |
| done_count | output | CNT_W | Count of bytes read in the captured request |
| err | output | 1 | One-cycle pulse on abort |
| err_status | output | 8 | Last status code observed |
| reg_wr_en | output | 1 | Controller register write strobe |
| reg_rd_en | output | 1 | Controller register read strobe |
| reg_addr | output | 5 | Controller register byte address |
| reg_wdata | output | 8 | Controller register write data |
| reg_rdata | input | 8 | Controller read data, valid the cycle after reg_rd_en |

## Verification
A wrong step pointer or a skipped state shows up at once on the register port: a control value, address byte or offset byte arrives out of order, or is missing, within a single transaction. A poll counter or delay counter that is off by one changes the spacing of status reads on the very next poll. It also changes the abort point after MAX_POLLS reads. Mishandling of the read countdown or the ACK choice appears as a wrong byte count, or as a wrong last-byte control value, before `done`.

// File: rtl/i2c_rdseq_pkg.sv
package i2c_rdseq_pkg;

    // Controller register byte addresses (decoded by the controller)
    localparam logic [4:0] RA_SLV  = 5'h00;
    localparam logic [4:0] RA_DATA = 5'h04;
    localparam logic [4:0] RA_CTRL = 5'h08;
    localparam logic [4:0] RA_STAT = 5'h0C; // status on read, baud on write
    localparam logic [4:0] RA_XSLV = 5'h10;
    localparam logic [4:0] RA_SRST = 5'h1C;

    // Control register bits
    localparam logic [7:0] CB_ACK   = 8'h04;
    localparam logic [7:0] CB_STOP  = 8'h10;
    localparam logic [7:0] CB_START = 8'h20;
    localparam logic [7:0] CB_EN    = 8'h40;

    localparam logic [7:0] BAUD_VAL = 8'h24;

    // Status codes
    localparam logic [7:0] ST_IDLE_CODE = 8'hF8;
    localparam logic [7:0] ST_STARTED   = 8'h08;
    localparam logic [7:0] ST_RESTARTED = 8'h10;
    localparam logic [7:0] ST_AW_ACK    = 8'h18;
    localparam logic [7:0] ST_WB_ACK    = 8'h28;
    localparam logic [7:0] ST_AR_ACK    = 8'h40;
    localparam logic [7:0] ST_RB_ACK    = 8'h50;
    localparam logic [7:0] ST_RB_NACK   = 8'h58;

    typedef enum logic [3:0] {
        SP_ENABLE, SP_START, SP_ADDR_W, SP_OFS_HI, SP_OFS_LO,
        SP_RSTART, SP_ADDR_R, SP_READ, SP_STOP
    } step_e;

    typedef enum logic [3:0] {
        S_IDLE, S_INIT, S_ISSUE, S_WAIT, S_POLL_RD, S_POLL_CHK,
        S_DATA_RD, S_DATA_CAP, S_NEXT, S_DONE, S_ERR
    } state_e;

endpackage

// File: rtl/i2c_rdseq_step.sv
module i2c_rdseq_step
    import i2c_rdseq_pkg::*;
(
    input  step_e      step,
    input  logic [7:0] dev_addr,
    input  logic [15:0] offset,
    input  logic       last_byte,
    output logic       has_data,
    output logic [7:0] wdata,
    output logic [7:0] ctrl,
    output logic [7:0] expect_code,
    output logic       is_read
);

    always_comb begin
        has_data    = 1'b0;
        wdata       = 8'h00;
        ctrl        = CB_EN;
        expect_code = ST_IDLE_CODE;
        is_read     = 1'b0;
        unique case (step)
            SP_ENABLE: begin
                expect_code = ST_IDLE_CODE;
            end
            SP_START: begin
                ctrl        = CB_EN | CB_START;
                expect_code = ST_STARTED;
            end
            SP_ADDR_W: begin
                has_data    = 1'b1;
                wdata       = {dev_addr[7:1], 1'b0};
                expect_code = ST_AW_ACK;
            end
            SP_OFS_HI: begin
                has_data    = 1'b1;
                wdata       = offset[15:8];
                expect_code = ST_WB_ACK;
            end
            SP_OFS_LO: begin
                has_data    = 1'b1;
                wdata       = offset[7:0];
                expect_code = ST_WB_ACK;
            end
            SP_RSTART: begin
                ctrl        = CB_EN | CB_START;
                expect_code = ST_RESTARTED;
            end
            SP_ADDR_R: begin
                has_data    = 1'b1;
                wdata       = {dev_addr[7:1], 1'b1};
                expect_code = ST_AR_ACK;
            end
            SP_READ: begin
                is_read     = 1'b1;
                ctrl        = last_byte ? CB_EN : (CB_EN | CB_ACK);
                expect_code = last_byte ? ST_RB_NACK : ST_RB_ACK;
            end
            SP_STOP: begin
                ctrl        = CB_EN | CB_STOP;
                expect_code = ST_IDLE_CODE;
            end
            default: begin
                expect_code = ST_IDLE_CODE;
            end
        endcase
    end

endmodule

// File: rtl/i2c_rdseq_poll.sv
module i2c_rdseq_poll #(
    parameter int POLL_DELAY = 10,
    parameter int MAX_POLLS  = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic in_wait,
    input  logic retry,
    output logic delay_done,
    output logic last_poll
);

    localparam int DW = $clog2(POLL_DELAY + 1);
    localparam int PW = $clog2(MAX_POLLS + 1);

    logic [DW-1:0] dly_q;
    logic [PW-1:0] polls_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_q <= '0;
        end else if (!in_wait) begin
            dly_q <= '0;
        end else begin
            dly_q <= dly_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            polls_q <= '0;
        end else if (arm) begin
            polls_q <= '0;
        end else if (retry) begin
            polls_q <= polls_q + 1'b1;
        end
    end

    assign delay_done = in_wait && (dly_q == DW'(POLL_DELAY - 1));
    assign last_poll  = (polls_q == PW'(MAX_POLLS - 1));

    // R7: the sequencer never retries once the budget is spent
    p_poll_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        retry |-> !last_poll);

    // R7: a wait period never runs beyond the delay
    p_wait_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait && dly_q == DW'(POLL_DELAY - 1)) |=> !in_wait);

endmodule

// File: rtl/i2c_rdseq.sv
module i2c_rdseq
    import i2c_rdseq_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int POLL_DELAY = 10,
    parameter int MAX_POLLS  = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       dev_addr,
    input  logic [15:0]      offset,
    input  logic             offset_two,
    input  logic [CNT_W-1:0] count,
    output logic             busy,
    output logic             rx_valid,
    output logic [7:0]       rx_data,
    output logic             done,
    output logic [CNT_W-1:0] done_count,
    output logic             err,
    output logic [7:0]       err_status,
    output logic             reg_wr_en,
    output logic             reg_rd_en,
    output logic [4:0]       reg_addr,
    output logic [7:0]       reg_wdata,
    input  logic [7:0]       reg_rdata
);

    state_e           state;
    step_e            step;
    logic [1:0]       init_idx;
    logic             data_sent;
    logic [7:0]       dev_q;
    logic [15:0]      ofs_q;
    logic             two_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] remain_q;
    logic [7:0]       last_status;

    logic       s_has_data;
    logic [7:0] s_wdata;
    logic [7:0] s_ctrl;
    logic [7:0] s_expect;
    logic       s_is_read;
    logic       last_byte;
    logic       status_match;
    logic       delay_done;
    logic       last_poll;
    logic       poll_arm;
    logic       poll_retry;

    assign last_byte    = (remain_q == CNT_W'(1));
    assign status_match = (reg_rdata == s_expect);
    assign poll_arm     = (state == S_ISSUE);
    assign poll_retry   = (state == S_POLL_CHK) && !status_match && !last_poll;

    i2c_rdseq_step u_step (
        .step        (step),
        .dev_addr    (dev_q),
        .offset      (ofs_q),
        .last_byte   (last_byte),
        .has_data    (s_has_data),
        .wdata       (s_wdata),
        .ctrl        (s_ctrl),
        .expect_code (s_expect),
        .is_read     (s_is_read)
    );

    i2c_rdseq_poll #(
        .POLL_DELAY (POLL_DELAY),
        .MAX_POLLS  (MAX_POLLS)
    ) u_poll (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (poll_arm),
        .in_wait    (state == S_WAIT),
        .retry      (poll_retry),
        .delay_done (delay_done),
        .last_poll  (last_poll)
    );

    // State register and captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= S_IDLE;
            step        <= SP_ENABLE;
            init_idx    <= '0;
            data_sent   <= 1'b0;
            dev_q       <= '0;
            ofs_q       <= '0;
            two_q       <= 1'b0;
            cnt_q       <= '0;
            remain_q    <= '0;
            last_status <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        if (count == '0) begin
                            last_status <= 8'h00;
                            state       <= S_ERR;
                        end else begin
                            dev_q    <= dev_addr;
                            ofs_q    <= offset;
                            two_q    <= offset_two;
                            cnt_q    <= count;
                            remain_q <= count;
                            init_idx <= '0;
                            state    <= S_INIT;
                        end
                    end
                end
                S_INIT: begin
                    init_idx <= init_idx + 1'b1;
                    if (init_idx == 2'd3) begin
                        step  <= SP_ENABLE;
                        state <= S_ISSUE;
                    end
                end
                S_ISSUE: begin
                    if (s_has_data && !data_sent) begin
                        data_sent <= 1'b1;
                    end else begin
                        data_sent <= 1'b0;
                        state     <= S_WAIT;
                    end
                end
                S_WAIT: begin
                    if (delay_done) state <= S_POLL_RD;
                end
                S_POLL_RD: begin
                    state <= S_POLL_CHK;
                end
                S_POLL_CHK: begin
                    last_status <= reg_rdata;
                    if (status_match) begin
                        state <= s_is_read ? S_DATA_RD : S_NEXT;
                    end else if (last_poll) begin
                        state <= S_ERR;
                    end else begin
                        state <= S_WAIT;
                    end
                end
                S_DATA_RD: begin
                    state <= S_DATA_CAP;
                end
                S_DATA_CAP: begin
                    remain_q <= remain_q - 1'b1;
                    state    <= S_NEXT;
                end
                S_NEXT: begin
                    state <= S_ISSUE;
                    unique case (step)
                        SP_ENABLE: step <= SP_START;
                        SP_START:  step <= SP_ADDR_W;
                        SP_ADDR_W: step <= two_q ? SP_OFS_HI : SP_OFS_LO;
                        SP_OFS_HI: step <= SP_OFS_LO;
                        SP_OFS_LO: step <= SP_RSTART;
                        SP_RSTART: step <= SP_ADDR_R;
                        SP_ADDR_R: step <= SP_READ;
                        SP_READ:   step <= (remain_q != '0) ? SP_READ : SP_STOP;
                        SP_STOP:   state <= S_DONE;
                        default:   state <= S_ERR;
                    endcase
                end
                S_DONE: state <= S_IDLE;
                S_ERR:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Outputs decoded from the state
    always_comb begin
        reg_wr_en = 1'b0;
        reg_rd_en = 1'b0;
        reg_addr  = RA_SLV;
        reg_wdata = 8'h00;
        rx_valid  = 1'b0;
        rx_data   = 8'h00;
        done      = 1'b0;
        err       = 1'b0;
        unique case (state)
            S_INIT: begin
                reg_wr_en = 1'b1;
                unique case (init_idx)
                    2'd0: reg_addr = RA_SRST;
                    2'd1: reg_addr = RA_SLV;
                    2'd2: reg_addr = RA_XSLV;
                    2'd3: begin
                        reg_addr  = RA_STAT;
                        reg_wdata = BAUD_VAL;
                    end
                    default: reg_addr = RA_SRST;
                endcase
            end
            S_ISSUE: begin
                reg_wr_en = 1'b1;
                if (s_has_data && !data_sent) begin
                    reg_addr  = RA_DATA;
                    reg_wdata = s_wdata;
                end else begin
                    reg_addr  = RA_CTRL;
                    reg_wdata = s_ctrl;
                end
            end
            S_POLL_RD: begin
                reg_rd_en = 1'b1;
                reg_addr  = RA_STAT;
            end
            S_DATA_RD: begin
                reg_rd_en = 1'b1;
                reg_addr  = RA_DATA;
            end
            S_DATA_CAP: begin
                rx_valid = 1'b1;
                rx_data  = reg_rdata;
            end
            S_DONE: done = 1'b1;
            S_ERR:  err  = 1'b1;
            default: begin
                reg_wr_en = 1'b0;
            end
        endcase
    end

    assign busy       = (state != S_IDLE);
    assign done_count = cnt_q;
    assign err_status = last_status;

    // R6: one controller access per cycle
    p_single_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && reg_rd_en));

    // R6: a byte-carrying control write follows a data write
    p_data_then_ctrl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == RA_CTRL && s_has_data)
        |-> $past(reg_wr_en && reg_addr == RA_DATA));

    // R8: zero count is rejected without bus access
    p_zero_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && count == '0) |=> (err && !reg_wr_en && !reg_rd_en));

    // R9: a start while busy leaves the captured request alone
    p_busy_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(done_count));

    // R5: completion and abort are exclusive
    p_done_err_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    // R4: a delivered byte comes from a data register read
    p_rx_from_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(reg_rd_en && reg_addr == RA_DATA));

endmodule

// File: tb/tb_i2c_rdseq.sv
module tb_i2c_rdseq;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;
    localparam int POLL_DELAY = 10;
    localparam int MAX_POLLS  = 1000;
    localparam int LAT        = 25;
    localparam int NVEC       = 4;

    // {dev, offset, two, count}
    localparam logic [32:0] VECS [NVEC] = '{
        {8'hA0, 16'h0010, 1'b0, 8'd1},
        {8'hA0, 16'h1234, 1'b1, 8'd4},
        {8'hAE, 16'h00FF, 1'b0, 8'd3},
        {8'hA2, 16'hBEEF, 1'b1, 8'd2}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [7:0] dev_addr = '0;
    logic [15:0] offset = '0;
    logic offset_two = 1'b0;
    logic [CNT_W-1:0] count = '0;
    logic busy, rx_valid, done, err, reg_wr_en, reg_rd_en;
    logic [7:0] rx_data, err_status, reg_wdata;
    logic [7:0] reg_rdata = '0;
    logic [CNT_W-1:0] done_count;
    logic [4:0] reg_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_rdseq #(.CNT_W(CNT_W), .POLL_DELAY(POLL_DELAY), .MAX_POLLS(MAX_POLLS)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dev_addr(dev_addr),
        .offset(offset), .offset_two(offset_two), .count(count),
        .busy(busy), .rx_valid(rx_valid), .rx_data(rx_data), .done(done),
        .done_count(done_count), .err(err), .err_status(err_status),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    int nchk = 0;
    int nerr = 0;

    function automatic logic [7:0] memf(input logic [15:0] a);
        return (a[7:0] * 8'd3) ^ a[15:8] ^ 8'hA5;
    endfunction

    // ---------------- behavioural controller model ----------------
    logic       model_clr = 1'b0;
    bit         nack_mode = 0;
    bit         stuck_mode = 0;
    logic [7:0] m_status, m_pend, m_data, m_rbyte;
    int         m_lat, m_phase;
    bit         m_started, m_fresh;
    logic [15:0] m_ptr;
    logic [4:0] wa [64];
    logic [7:0] wd [64];
    int         wn, rd_total, seq_err, rd_since_ctrl, last_rd, gap, first_gap, cyc;
    int         last_wr;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (model_clr) begin
            m_status <= 8'hF8; m_pend <= 8'hF8; m_data <= 0; m_rbyte <= 0;
            m_lat <= 0; m_phase <= 0; m_started <= 0; m_fresh <= 0; m_ptr <= 0;
            wn <= 0; rd_total <= 0; seq_err <= 0; rd_since_ctrl <= 0;
            last_rd <= 0; gap <= 0; first_gap <= 0; last_wr <= 0;
        end else begin
            logic [7:0] code;
            if (m_lat > 0) begin
                m_lat <= m_lat - 1;
                if (m_lat == 1) m_status <= m_pend;
            end
            if (reg_rd_en) begin
                rd_total <= rd_total + 1;
                if (reg_addr == 5'h0C) begin
                    reg_rdata <= m_status;
                    if (rd_since_ctrl == 0) first_gap <= cyc - last_wr;
                    rd_since_ctrl <= rd_since_ctrl + 1;
                    gap <= cyc - last_rd;
                    last_rd <= cyc;
                end else if (reg_addr == 5'h04) begin
                    reg_rdata <= m_rbyte;
                    if (m_lat != 0) seq_err <= seq_err + 1;
                end else begin
                    reg_rdata <= 8'h00;
                end
            end
            if (reg_wr_en) begin
                if (wn < 64) begin wa[wn] <= reg_addr; wd[wn] <= reg_wdata; end
                wn <= wn + 1;
                if (reg_addr == 5'h04) begin
                    m_data <= reg_wdata; m_fresh <= 1;
                end else if (reg_addr == 5'h08) begin
                    code = 8'hF8;
                    if (reg_wdata & 8'h10) begin
                        code = 8'hF8; m_phase <= 0;
                    end else if (reg_wdata & 8'h20) begin
                        code = m_started ? 8'h10 : 8'h08;
                        if (!m_started) m_ptr <= 0;
                        m_started <= 1; m_phase <= 1;
                    end else if (m_phase == 1) begin
                        if (!m_fresh) seq_err <= seq_err + 1;
                        if (nack_mode) code = m_data[0] ? 8'h48 : 8'h20;
                        else if (m_data[0]) begin code = 8'h40; m_phase <= 3; end
                        else begin code = 8'h18; m_phase <= 2; end
                    end else if (m_phase == 2) begin
                        if (!m_fresh) seq_err <= seq_err + 1;
                        code = 8'h28;
                        m_ptr <= {m_ptr[7:0], m_data};
                    end else if (m_phase == 3) begin
                        code = (reg_wdata & 8'h04) ? 8'h50 : 8'h58;
                        m_rbyte <= memf(m_ptr);
                        m_ptr <= m_ptr + 1;
                    end
                    m_fresh <= 0;
                    m_status <= 8'hF8;
                    m_pend <= code;
                    m_lat <= (stuck_mode && (reg_wdata & 8'h20)) ? 0 : LAT;
                    rd_since_ctrl <= 0;
                    last_wr <= cyc;
                end
            end
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    initial begin
        #(CLK_PERIOD * 180000);
        nchk++; nerr++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    logic [7:0] rxb [64];
    int  rxn;
    bit  saw_done, saw_err;
    int  done_cnt_seen;
    logic [7:0] err_st_seen;

    task automatic model_reset();
        @(negedge clk); model_clr = 1;
        @(negedge clk); model_clr = 0;
    endtask

    task automatic run(input logic [7:0] dv, input logic [15:0] of, input bit two,
                       input int cnt, input int inject_at, input int limit);
        rxn = 0; saw_done = 0; saw_err = 0;
        @(negedge clk);
        start = 1; dev_addr = dv; offset = of; offset_two = two; count = CNT_W'(cnt);
        @(negedge clk);
        start = 0;
        for (int k = 0; k < limit; k++) begin
            if (k == inject_at) begin start = 1; count = 8'd7; offset = 16'h4444; end
            else start = 0;
            if (rx_valid && rxn < 64) begin rxb[rxn] = rx_data; rxn++; end
            if (done) begin saw_done = 1; done_cnt_seen = done_count; end
            if (err) begin saw_err = 1; err_st_seen = err_status; end
            if (saw_done || saw_err) break;
            @(negedge clk);
        end
        start = 0;
    endtask

    task automatic check_vector(input logic [7:0] dv, input logic [15:0] of,
                                input bit two, input int cnt);
        int exp_ctrl [64];
        int ne = 0;
        int nc = 0;
        int bad = 0;
        logic [15:0] base;
        logic [7:0] exp_data [4];
        int nd = 0;
        chk(saw_done && !saw_err, "R5", "done without err", saw_done, 1);
        chk(done_cnt_seen == cnt, "R5", "done_count", done_cnt_seen, cnt);
        chk(rxn == cnt, "R4", "byte count", rxn, cnt);
        base = two ? of : {8'h00, of[7:0]};
        for (int i = 0; i < cnt && i < rxn; i++)
            chk(rxb[i] == memf(base + 16'(i)), "R4", "read byte", rxb[i], memf(base + 16'(i)));
        // R1 init writes
        chk(wa[0] == 5'h1C && wd[0] == 0 && wa[1] == 5'h00 && wd[1] == 0 &&
            wa[2] == 5'h10 && wd[2] == 0 && wa[3] == 5'h0C && wd[3] == 8'h24,
            "R1", "init writes", {wa[3], wd[3]}, {5'h0C, 8'h24});
        chk(wa[4] == 5'h08 && wd[4] == 8'h40, "R1", "enable write", wd[4], 8'h40);
        // R2/R4/R5 control sequence
        exp_ctrl[ne++] = 8'h40; exp_ctrl[ne++] = 8'h60; exp_ctrl[ne++] = 8'h40;
        if (two) exp_ctrl[ne++] = 8'h40;
        exp_ctrl[ne++] = 8'h40; exp_ctrl[ne++] = 8'h60; exp_ctrl[ne++] = 8'h40;
        for (int i = 0; i < cnt - 1; i++) exp_ctrl[ne++] = 8'h44;
        exp_ctrl[ne++] = 8'h40; exp_ctrl[ne++] = 8'h50;
        for (int i = 0; i < wn && i < 64; i++) begin
            if (wa[i] == 5'h08) begin
                if (nc >= ne || wd[i] != exp_ctrl[nc][7:0]) bad++;
                nc++;
            end
        end
        chk(nc == ne && bad == 0, "R2", "control write sequence", bad, 0);
        // R3 address and offset bytes
        exp_data[nd++] = {dv[7:1], 1'b0};
        if (two) exp_data[nd++] = of[15:8];
        exp_data[nd++] = of[7:0];
        exp_data[nd++] = {dv[7:1], 1'b1};
        nc = 0; bad = 0;
        for (int i = 0; i < wn && i < 64; i++) begin
            if (wa[i] == 5'h04) begin
                if (nc >= nd || wd[i] != exp_data[nc]) bad++;
                nc++;
            end
        end
        chk(nc == nd && bad == 0, "R3", "address/offset bytes", nc, nd);
        chk(seq_err == 0, "R6", "data/control ordering", seq_err, 0);
    endtask

    initial begin
        // R10 reset state
        #(CLK_PERIOD * 3);
        @(negedge clk);
        chk(!busy && !done && !err && !rx_valid && !reg_wr_en && !reg_rd_en,
            "R10", "outputs in reset", {busy, done, err, rx_valid, reg_wr_en, reg_rd_en}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !reg_wr_en && !reg_rd_en, "R10", "idle after reset",
            {busy, reg_wr_en, reg_rd_en}, 0);

        // Table of vectors (R1..R6)
        for (int v = 0; v < NVEC; v++) begin
            model_reset();
            run(VECS[v][32:25], VECS[v][24:9], VECS[v][8], int'(VECS[v][7:0]), -1, 20000);
            check_vector(VECS[v][32:25], VECS[v][24:9], VECS[v][8], int'(VECS[v][7:0]));
        end

        // R8 zero count rejected
        model_reset();
        run(8'hA0, 16'h0001, 1'b0, 0, -1, 100);
        repeat (3) @(negedge clk);
        chk(saw_err && !saw_done, "R8", "zero count error", saw_err, 1);
        chk(err_st_seen == 8'h00, "R8", "zero count status", err_st_seen, 0);
        chk(wn == 0 && rd_total == 0, "R8", "no bus access", wn + rd_total, 0);

        // R9 start while busy ignored
        model_reset();
        run(8'hA0, 16'h0020, 1'b0, 2, 50, 20000);
        chk(saw_done && done_cnt_seen == 2, "R9", "count kept", done_cnt_seen, 2);
        chk(rxn == 2 && rxb[0] == memf(16'h0020), "R9", "data from first request",
            rxb[0], memf(16'h0020));

        // R7 timeout on address not acknowledged
        model_reset();
        nack_mode = 1;
        run(8'hA0, 16'h0005, 1'b0, 1, -1, 40000);
        nack_mode = 0;
        chk(saw_err && !saw_done, "R7", "abort on missing ack", saw_err, 1);
        chk(err_st_seen == 8'h20, "R7", "last status", err_st_seen, 8'h20);
        chk(rd_since_ctrl == MAX_POLLS, "R7", "poll count", rd_since_ctrl, MAX_POLLS);
        chk(gap == POLL_DELAY + 2, "R7", "poll spacing", gap, POLL_DELAY + 2);
        chk(first_gap == POLL_DELAY + 1, "R7", "first poll delay", first_gap, POLL_DELAY + 1);
        chk(rxn == 0, "R7", "no data on abort", rxn, 0);

        // R7 timeout with status never changing
        model_reset();
        stuck_mode = 1;
        run(8'hA0, 16'h0005, 1'b0, 1, -1, 40000);
        stuck_mode = 0;
        chk(saw_err && err_st_seen == 8'hF8, "R7", "stuck status abort", err_st_seen, 8'hF8);

        summary();
        $finish;
    end

endmodule